// File: doc/BRIEF.md
# Wide-Bank Cartridge Memory Controller

This block sits between a CPU with a 16-bit address space and a cartridge's ROM and battery-free external RAM. It holds a 9-bit ROM bank number and a 4-bit RAM bank number in registers. It turns every CPU access into a physical ROM or RAM address. The 9-bit ROM bank number is loaded by two separate write windows: one carries the low byte and the other carries the ninth bit. Unlike narrower controllers, bank 0 is a legal choice for the switchable ROM window and is never replaced by bank 1.

CPU writes into the ROM address range do not reach ROM. They program the controller instead. An 8-bit key enables or disables the external RAM window, and while that window is disabled, reads return all ones and writes are dropped. The physical ROM address is cut to `ROM_AW` bits, so bank numbers beyond the fitted ROM wrap around. The bank registers change on the clock edge that ends a write cycle. The address and data outputs are combinational from the current CPU cycle and the registered bank state.

Top module: `wide_bank_mapper`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0 and external RAM is disabled. A read of 0x4000 gives ROM address 0x4000, and a read of 0xA000 returns 0xFF with `ram_cs` low.
- R2: A read of 0x0000–0x3FFF drives `rom_cs` high, puts address bits [13:0] on `rom_addr` with all upper bits zero, and returns `rom_rdata` on `cpu_rdata`. A write to any ROM-range address leaves `rom_cs` low.
- R3: A read of 0x4000–0x7FFF drives `rom_addr` = ROM bank × 0x4000 + (address − 0x4000), truncated to the low `ROM_AW` bits.
- R4: A write to 0x2000–0x2FFF loads ROM bank bits [7:0] from the data byte and keeps bit 8. A value of 0 stays 0, so the banked window then maps to physical 0x0000.
- R5: A write to 0x3000–0x3FFF loads ROM bank bit 8 from data bit 0 and keeps bits [7:0].
- R6: A write to 0x4000–0x5FFF loads the RAM bank from data bits [3:0]. Data bits [7:4] are ignored.
- R7: A write to 0x0000–0x1FFF enables external RAM when the data is exactly 0x0A and disables it for any other value.
- R8: While enabled, an access to 0xA000–0xBFFF drives `ram_cs` and `ram_addr` = RAM bank × 0x2000 + (address − 0xA000). A write also drives `ram_we` with `ram_wdata` equal to the CPU data, and a read returns `ram_rdata`.
- R9: While disabled, an access to 0xA000–0xBFFF keeps `ram_cs` and `ram_we` low, and a read returns 0xFF.
- R10: Writes to 0x6000–0x7FFF, to the RAM window, or outside both windows leave the bank numbers and the enable flag unchanged.
- R11: An access to 0x8000–0x9FFF or 0xC000–0xFFFF drives neither chip select, and a read returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe; bank state updates on the following edge |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| rom_rdata | input | 8 | Data from ROM |
| rom_addr | output | ROM_AW | Physical ROM address |
| rom_cs | output | 1 | ROM read select |
| ram_rdata | input | 8 | Data from external RAM |
| ram_addr | output | RAM_AW | Physical external RAM address |
| ram_cs | output | 1 | External RAM select |
| ram_we | output | 1 | External RAM write enable |
| ram_wdata | output | 8 | External RAM write data |

## Verification
The hardest states to reach from the ports are those where the two halves of the ROM bank disagree with what either write alone would give. Examples are bit 8 set while the low byte is zero, and a later low-byte write that must not disturb bit 8. A second instance with a narrow `ROM_AW` must then show the upper bank bits truncated. Directed writes build these states first: bank 0x000, then 0x100, 0x1AB and 0x0AB. A seeded random phase follows that spreads writes over every control window, with the enable key written about half the time. This way RAM accesses land in both the enabled and the disabled state under many bank values, and a bench model predicts every output.

// File: rtl/wbm_pkg.sv
`timescale 1ns/1ps
package wbm_pkg;

    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 8;
    localparam int ROM_BANK_W  = 9;
    localparam int RAM_BANK_W  = 4;
    localparam int ROM_WIN_W   = 14;
    localparam int RAM_WIN_W   = 13;
    localparam int ROM_FULL_W  = ROM_BANK_W + ROM_WIN_W;
    localparam int RAM_FULL_W  = RAM_BANK_W + RAM_WIN_W;
    localparam logic [DATA_W-1:0] ENABLE_KEY = 8'h0A;
    localparam logic [DATA_W-1:0] OPEN_BUS   = 8'hFF;

    typedef enum logic [1:0] {
        RGN_ROM_FIXED,
        RGN_ROM_BANKED,
        RGN_RAM,
        RGN_NONE
    } region_e;

    typedef struct packed {
        logic en_key;
        logic bank_lo;
        logic bank_hi;
        logic ram_bank;
    } wr_cmd_t;

    typedef struct packed {
        logic [ROM_BANK_W-1:0] rom_bank;
        logic [RAM_BANK_W-1:0] ram_bank;
        logic                  ram_en;
    } bank_state_t;

endpackage

// File: rtl/wbm_decode.sv
`timescale 1ns/1ps
module wbm_decode
    import wbm_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output region_e           region,
    output wr_cmd_t           cmd
);

    always_comb begin
        if (!addr[15]) begin
            region = addr[14] ? RGN_ROM_BANKED : RGN_ROM_FIXED;
        end else if (addr[15:13] == 3'b101) begin
            region = RGN_RAM;
        end else begin
            region = RGN_NONE;
        end
    end

    always_comb begin
        cmd          = '0;
        cmd.en_key   = wr && (addr[15:13] == 3'b000);
        cmd.bank_lo  = wr && (addr[15:12] == 4'h2);
        cmd.bank_hi  = wr && (addr[15:12] == 4'h3);
        cmd.ram_bank = wr && (addr[15:13] == 3'b010);
    end

endmodule

// File: rtl/wbm_regs.sv
`timescale 1ns/1ps
module wbm_regs
    import wbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wr_cmd_t           cmd,
    input  logic [DATA_W-1:0] wdata,
    output bank_state_t       st_q
);

    localparam int HI_W = ROM_BANK_W - DATA_W;
    localparam logic [ROM_BANK_W-1:0] RESET_BANK = ROM_BANK_W'(1);

    bank_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (cmd.en_key) begin
            st_d.ram_en = (wdata == ENABLE_KEY);
        end
        if (cmd.bank_lo) begin
            st_d.rom_bank[DATA_W-1:0] = wdata;
        end
        if (cmd.bank_hi) begin
            st_d.rom_bank[ROM_BANK_W-1:DATA_W] = wdata[HI_W-1:0];
        end
        if (cmd.ram_bank) begin
            st_d.ram_bank = wdata[RAM_BANK_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rom_bank <= RESET_BANK;
            st_q.ram_bank <= '0;
            st_q.ram_en   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wbm_xlate.sv
`timescale 1ns/1ps
module wbm_xlate
    import wbm_pkg::*;
#(
    parameter int ROM_AW = 23,
    parameter int RAM_AW = 17
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  region_e           region,
    input  bank_state_t       st,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_cs,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_cs,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [DATA_W-1:0] cpu_rdata
);

    logic [ROM_BANK_W-1:0] bank_sel;
    logic [ROM_FULL_W-1:0] rom_full;
    logic [RAM_FULL_W-1:0] ram_full;
    logic                  ram_live;

    always_comb begin
        bank_sel = (region == RGN_ROM_BANKED) ? st.rom_bank : '0;
        rom_full = {bank_sel, addr[ROM_WIN_W-1:0]};
        ram_full = {st.ram_bank, addr[RAM_WIN_W-1:0]};
        ram_live = (region == RGN_RAM) && st.ram_en;

        rom_addr  = rom_full[ROM_AW-1:0];
        ram_addr  = ram_full[RAM_AW-1:0];
        rom_cs    = rd && ((region == RGN_ROM_FIXED) || (region == RGN_ROM_BANKED));
        ram_cs    = ram_live && (rd || wr);
        ram_we    = ram_live && wr;
        ram_wdata = wdata;

        unique case (region)
            RGN_ROM_FIXED, RGN_ROM_BANKED: cpu_rdata = rom_rdata;
            RGN_RAM:                       cpu_rdata = st.ram_en ? ram_rdata : OPEN_BUS;
            default:                       cpu_rdata = OPEN_BUS;
        endcase
    end

endmodule

// File: rtl/wide_bank_mapper.sv
`timescale 1ns/1ps
module wide_bank_mapper
    import wbm_pkg::*;
#(
    parameter int ROM_AW = 23,
    parameter int RAM_AW = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [7:0]        cpu_rdata,
    input  logic [7:0]        rom_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_cs,
    input  logic [7:0]        ram_rdata,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_cs,
    output logic              ram_we,
    output logic [7:0]        ram_wdata
);

    region_e     region;
    wr_cmd_t     cmd;
    bank_state_t st_q;

    logic [ROM_BANK_W-1:0] rom_bank_q;
    logic [RAM_BANK_W-1:0] ram_bank_q;
    logic                  ram_en_q;

    assign rom_bank_q = st_q.rom_bank;
    assign ram_bank_q = st_q.ram_bank;
    assign ram_en_q   = st_q.ram_en;

    wbm_decode u_decode (
        .addr   (cpu_addr),
        .wr     (cpu_wr),
        .region (region),
        .cmd    (cmd)
    );

    wbm_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .wdata (cpu_wdata),
        .st_q  (st_q)
    );

    wbm_xlate #(
        .ROM_AW (ROM_AW),
        .RAM_AW (RAM_AW)
    ) u_xlate (
        .addr      (cpu_addr),
        .rd        (cpu_rd),
        .wr        (cpu_wr),
        .wdata     (cpu_wdata),
        .region    (region),
        .st        (st_q),
        .rom_rdata (rom_rdata),
        .ram_rdata (ram_rdata),
        .rom_addr  (rom_addr),
        .rom_cs    (rom_cs),
        .ram_addr  (ram_addr),
        .ram_cs    (ram_cs),
        .ram_we    (ram_we),
        .ram_wdata (ram_wdata),
        .cpu_rdata (cpu_rdata)
    );

endmodule

// File: rtl/wbm_checker.sv
`timescale 1ns/1ps
module wbm_checker #(
    parameter int ROM_AW = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [7:0]        cpu_rdata,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              rom_cs,
    input logic              ram_cs,
    input logic              ram_we,
    input logic [8:0]        rom_bank,
    input logic [3:0]        ram_bank,
    input logic              ram_en
);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (rom_bank == 9'd1 && ram_bank == 4'd0 && !ram_en));

    assert_fixed_rom_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr[15:14] == 2'b00) |-> (rom_cs && rom_addr == ROM_AW'(cpu_addr[13:0])));

    assert_bank_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:12] == 4'h2) |=>
        (rom_bank[7:0] == $past(cpu_wdata) && rom_bank[8] == $past(rom_bank[8])));

    assert_bank_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:12] == 4'h3) |=>
        (rom_bank[8] == $past(cpu_wdata[0]) && rom_bank[7:0] == $past(rom_bank[7:0])));

    assert_ram_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b010) |=> (ram_bank == $past(cpu_wdata[3:0])));

    assert_enable_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b000) |=> (ram_en == ($past(cpu_wdata) == 8'h0A)));

    assert_disabled_ram_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b101 && !ram_en) |->
        (!ram_cs && !ram_we && (!cpu_rd || cpu_rdata == 8'hFF)));

    assert_inert_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && (cpu_addr[15:13] == 3'b011 || cpu_addr[15])) |=>
        ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en)));

    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15] && cpu_addr[15:13] != 3'b101) |-> (!rom_cs && !ram_cs && !ram_we));

endmodule

bind wide_bank_mapper wbm_checker #(.ROM_AW(ROM_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_rdata (cpu_rdata),
    .rom_addr  (rom_addr),
    .rom_cs    (rom_cs),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .rom_bank  (rom_bank_q),
    .ram_bank  (ram_bank_q),
    .ram_en    (ram_en_q)
);

// File: tb/wide_bank_mapper_test.sv
`timescale 1ns/1ps
module wide_bank_mapper_test;

    localparam int WIDE_AW   = 23;
    localparam int NARROW_AW = 20;
    localparam int RAM_AW    = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  rom_rdata = 8'h00;
    logic [7:0]  ram_rdata = 8'h00;

    logic [7:0]           rdata_w, rdata_n, wdata_w, wdata_n;
    logic [WIDE_AW-1:0]   rom_addr_w;
    logic [NARROW_AW-1:0] rom_addr_n;
    logic [RAM_AW-1:0]    ram_addr_w, ram_addr_n;
    logic rom_cs_w, rom_cs_n, ram_cs_w, ram_cs_n, ram_we_w, ram_we_n;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [8:0] m_bank;
    logic [3:0] m_rb;
    logic       m_en;

    always #4 clk = ~clk;

    wide_bank_mapper #(.ROM_AW(WIDE_AW), .RAM_AW(RAM_AW)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(rdata_w), .rom_rdata(rom_rdata),
        .rom_addr(rom_addr_w), .rom_cs(rom_cs_w), .ram_rdata(ram_rdata),
        .ram_addr(ram_addr_w), .ram_cs(ram_cs_w), .ram_we(ram_we_w), .ram_wdata(wdata_w)
    );

    wide_bank_mapper #(.ROM_AW(NARROW_AW), .RAM_AW(RAM_AW)) uut_narrow (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(rdata_n), .rom_rdata(rom_rdata),
        .rom_addr(rom_addr_n), .rom_cs(rom_cs_n), .ram_rdata(ram_rdata),
        .ram_addr(ram_addr_n), .ram_cs(ram_cs_n), .ram_we(ram_we_n), .ram_wdata(wdata_n)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rom(input logic [15:0] a, input int aw);
        logic [31:0] full;
        full = a[14] ? {9'd0, m_bank, a[13:0]} : {18'd0, a[13:0]};
        return full & ((32'd1 << aw) - 32'd1);
    endfunction

    function automatic string auto_tag(input logic [15:0] a);
        if (!a[15]) return a[14] ? "R3" : "R2";
        if (a[15:13] == 3'b101) return m_en ? "R8" : "R9";
        return "R11";
    endfunction

    // One CPU cycle: drive, check the combinational outputs, then commit the edge.
    task automatic op(input bit is_wr, input logic [15:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr    = is_wr;
        cpu_rd    = !is_wr;
        rom_rdata = 8'($urandom);
        ram_rdata = 8'($urandom);
        #2;
        if (!a[15]) begin
            chk(tag, "rom_cs", {31'd0, rom_cs_w}, {31'd0, !is_wr});
            chk(tag, "rom_cs narrow", {31'd0, rom_cs_n}, {31'd0, !is_wr});
            chk(tag, "ram_cs", {31'd0, ram_cs_w}, 32'd0);
            if (!is_wr) begin
                chk(tag, "rom_addr", 32'(rom_addr_w), exp_rom(a, WIDE_AW));
                chk(tag, "rom_addr narrow", 32'(rom_addr_n), exp_rom(a, NARROW_AW));
                chk(tag, "rdata rom", 32'(rdata_w), 32'(rom_rdata));
            end
        end else if (a[15:13] == 3'b101) begin
            chk(tag, "ram_cs", {31'd0, ram_cs_w}, {31'd0, m_en});
            chk(tag, "ram_we", {31'd0, ram_we_w}, {31'd0, m_en && is_wr});
            chk(tag, "ram_we narrow", {31'd0, ram_we_n}, {31'd0, m_en && is_wr});
            chk(tag, "rom_cs", {31'd0, rom_cs_w}, 32'd0);
            if (m_en) begin
                chk(tag, "ram_addr", 32'(ram_addr_w), {15'd0, m_rb, a[12:0]});
                chk(tag, "ram_addr narrow", 32'(ram_addr_n), {15'd0, m_rb, a[12:0]});
                if (is_wr) chk(tag, "ram_wdata", 32'(wdata_w), 32'(d));
            end
            if (!is_wr) chk(tag, "rdata ram", 32'(rdata_w), m_en ? 32'(ram_rdata) : 32'hFF);
        end else begin
            chk(tag, "rom_cs", {31'd0, rom_cs_w}, 32'd0);
            chk(tag, "ram_cs", {31'd0, ram_cs_w}, 32'd0);
            chk(tag, "ram_we", {31'd0, ram_we_w}, 32'd0);
            if (!is_wr) chk(tag, "rdata open", 32'(rdata_n), 32'hFF);
        end
        @(posedge clk);
        #1;
        if (is_wr) begin
            if (a[15:13] == 3'b000) m_en = (d == 8'h0A);
            if (a[15:12] == 4'h2)   m_bank[7:0] = d;
            if (a[15:12] == 4'h3)   m_bank[8] = d[0];
            if (a[15:13] == 3'b010) m_rb = d[3:0];
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1B2C3D4E));
        m_bank = 9'd1;
        m_rb   = 4'd0;
        m_en   = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen through the ports
        op(1'b0, 16'h4000, 8'h00, "R1");
        op(1'b0, 16'hA000, 8'h00, "R1");
        // R2: fixed window
        op(1'b0, 16'h3ABC, 8'h00, "R2");
        // R7 and R8: enable, then access RAM
        op(1'b1, 16'h0000, 8'h0A, "R7");
        op(1'b0, 16'hA123, 8'h00, "R7");
        op(1'b1, 16'hA005, 8'h5C, "R8");
        // R4: bank 0 stays 0 in the banked window
        op(1'b1, 16'h2000, 8'h00, "R4");
        op(1'b0, 16'h4567, 8'h00, "R4");
        // R5: ninth bit alone, then low byte keeps it, then bit 8 cleared keeps low byte
        op(1'b1, 16'h3000, 8'h01, "R5");
        op(1'b0, 16'h7FFF, 8'h00, "R5");
        op(1'b1, 16'h2FFF, 8'hAB, "R4");
        op(1'b0, 16'h4001, 8'h00, "R4");
        op(1'b1, 16'h3FFF, 8'hFE, "R5");
        op(1'b0, 16'h6000, 8'h00, "R5");
        // R6: RAM bank from low nibble
        op(1'b1, 16'h4000, 8'hF7, "R6");
        op(1'b0, 16'hBFFF, 8'h00, "R6");
        // R10: inert writes
        op(1'b1, 16'h6000, 8'hFF, "R10");
        op(1'b1, 16'h8000, 8'h00, "R10");
        op(1'b1, 16'hC000, 8'h00, "R10");
        op(1'b1, 16'hB000, 8'h00, "R10");
        op(1'b0, 16'h5000, 8'h00, "R10");
        op(1'b0, 16'hA010, 8'h00, "R10");
        // R7 / R9: a near-miss key disables
        op(1'b1, 16'h1FFF, 8'h0B, "R7");
        op(1'b1, 16'hA000, 8'h11, "R9");
        op(1'b0, 16'hA000, 8'h00, "R9");
        // R11: outside both windows
        op(1'b0, 16'h9000, 8'h00, "R11");
        op(1'b0, 16'hFFFF, 8'h00, "R11");

        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            bit          w;
            int          k;
            k = int'($urandom % 8);
            d = 8'($urandom);
            w = 1'($urandom);
            unique case (k)
                0: begin a = 16'($urandom % 16'h2000); if ($urandom % 2 == 0) d = 8'h0A; end
                1: a = 16'h2000 + 16'($urandom % 16'h1000);
                2: a = 16'h3000 + 16'($urandom % 16'h1000);
                3: a = 16'h4000 + 16'($urandom % 16'h2000);
                4: a = 16'h6000 + 16'($urandom % 16'h2000);
                5, 6: a = 16'hA000 + 16'($urandom % 16'h2000);
                default: a = ($urandom % 2 == 0) ? 16'h8000 + 16'($urandom % 16'h2000)
                                                 : 16'hC000 + 16'($urandom % 16'h4000);
            endcase
            if (k <= 2 && !w && ($urandom % 2 == 0)) a = 16'h4000 | a;
            op(w, a, d, auto_tag(a));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule